// File: doc/BRIEF.md
# Two-Port Word Memory with Collision Arbitration

This block is a synchronous two-port memory. By default it holds 2048 words of 16 bits. There are two ports, called left (A) and right (B). Each port can read or write any word on its own, with its own address, write data, read data, enable, write strobe, output enable and one byte-lane enable per 8-bit lane. A read is registered: its data appears the clock edge after the request, together with a valid flag. When the valid flag is low the read data bus is held at zero, which stands for the high-impedance state of a real output pin.

If both enabled ports address the same word in the same cycle, an arbiter picks one winner. It pulls the other port's active-low busy flag down in that same cycle and suppresses that port's write. The losing port can still read. The arbiter remembers which port was already parked on a word, so a port that arrives later loses. When both ports arrive together, the left port wins.

A strap input selects master or slave mode. A master makes its own decision. A slave takes both busy flags from an external master and applies them to its own writes. This lets several slices share one decision and so form a wider word.

Top module: `dpram_arb`

## Requirements
- R1: A write with both lanes enabled stores the full word. A later read of that address shows the word on the read data bus one clock edge after the read request.
- R2: Lane bit 0 covers data bits 7:0 and lane bit 1 covers bits 15:8. A write changes only the enabled lanes. A read returns zero in every lane whose enable is low.
- R3: The read valid flag is high in the cycle after a request with enable high, output enable high and write low, and low otherwise. While valid is low, read data is zero.
- R4: While a port's enable is low, that port neither writes nor reads, whatever its other controls are.
- R5: In master mode, when both ports are enabled on one address and neither was on that address in the previous cycle, right busy goes low and left busy stays high in the same cycle.
- R6: In master mode, if exactly one port was already enabled on the address in the previous cycle, the other (newly arrived) port is flagged busy. While the collision continues on the same address, the same port stays flagged.
- R7: In master mode, a busy flag is low only while both ports are enabled on the same address. It returns high in the first cycle the addresses differ or either port is disabled.
- R8: A write on the port whose busy flag is low is blocked. The other port's write completes normally.
- R9: Both ports reading one word both receive its contents. If one port reads a word in the same cycle the other port writes it, the read returns the contents held before that write.
- R10: In slave mode, each busy output equals the matching external busy input. A low external busy input blocks writes on that port whatever the addresses are.
- R11: During reset both valid flags are low and both read data buses are zero. With both ports disabled, both busy flags are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_master | input | 1 | 1 = arbitrate internally, 0 = follow external busy |
| ext_a_busy_n | input | 1 | External busy for the left port (slave mode) |
| ext_b_busy_n | input | 1 | External busy for the right port (slave mode) |
| a_en | input | 1 | Left port enable |
| a_wr | input | 1 | Left port write strobe |
| a_oe | input | 1 | Left port output enable |
| a_be | input | DATA_W/8 | Left port lane enables |
| a_addr | input | ADDR_W | Left port word address |
| a_wdata | input | DATA_W | Left port write data |
| a_rdata | output | DATA_W | Left port read data |
| a_rvalid | output | 1 | Left port read data valid |
| a_busy_n | output | 1 | Left port busy, active low |
| b_en | input | 1 | Right port enable |
| b_wr | input | 1 | Right port write strobe |
| b_oe | input | 1 | Right port output enable |
| b_be | input | DATA_W/8 | Right port lane enables |
| b_addr | input | ADDR_W | Right port word address |
| b_wdata | input | DATA_W | Right port write data |
| b_rdata | output | DATA_W | Right port read data |
| b_rvalid | output | 1 | Right port read data valid |
| b_busy_n | output | 1 | Right port busy, active low |

## Verification
The bench builds the block with ADDR_W = 4 and DATA_W = 16. With only sixteen words, random addresses from the two ports collide in a large share of cycles. This brings every ownership case within reach many times over: a fresh tie, the left port parked, the right port parked, and a collision that persists. The two 8-bit lanes keep every partial-write and masked-read combination in play. The bench also switches into slave mode with random external busy levels, so that blocked writes can be seen without any address match.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
    // width of one byte lane, shared by storage and read path
    localparam int LANE_W = 8;
    // side indices used by the per-port read generate
    localparam int SIDE_A = 0;
    localparam int SIDE_B = 1;
    localparam int N_SIDES = 2;
endpackage

// File: rtl/dpram_arbiter.sv
module dpram_arbiter #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic              a_en,
    input  logic              b_en,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              ext_a_busy_n,
    input  logic              ext_b_busy_n,
    output logic              a_lose,
    output logic              b_lose
);
    // history of the previous cycle, used to tell who arrived first
    typedef struct packed {
        logic              a_en;
        logic              b_en;
        logic [ADDR_W-1:0] a_addr;
        logic [ADDR_W-1:0] b_addr;
        logic              win_a;
    } hist_t;

    hist_t hist_d, hist_q;
    logic  match;
    logic  a_held;
    logic  b_held;
    logic  win_a;

    always_comb begin
        match  = a_en && b_en && (a_addr == b_addr);
        a_held = hist_q.a_en && (hist_q.a_addr == a_addr);
        b_held = hist_q.b_en && (hist_q.b_addr == b_addr);

        // both parked: keep the earlier winner; only right parked: right wins
        if (a_held && b_held) begin
            win_a = hist_q.win_a;
        end else if (b_held) begin
            win_a = 1'b0;
        end else begin
            win_a = 1'b1;
        end

        if (is_master) begin
            a_lose = match && !win_a;
            b_lose = match && win_a;
        end else begin
            a_lose = !ext_a_busy_n;
            b_lose = !ext_b_busy_n;
        end

        hist_d        = hist_q;
        hist_d.a_en   = a_en;
        hist_d.b_en   = b_en;
        hist_d.a_addr = a_addr;
        hist_d.b_addr = b_addr;
        hist_d.win_a  = match ? win_a : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q.a_en   <= 1'b0;
            hist_q.b_en   <= 1'b0;
            hist_q.a_addr <= '0;
            hist_q.b_addr <= '0;
            hist_q.win_a  <= 1'b1;
        end else begin
            hist_q <= hist_d;
        end
    end
endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              a_we,
    input  logic [LANES-1:0]  a_lanes,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              b_we,
    input  logic [LANES-1:0]  b_lanes,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] a_word,
    output logic [DATA_W-1:0] b_word
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = DATA_W / LANES;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // right port first so the left port's lane persists on a shared write
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (b_we && b_lanes[i]) begin
                mem_q[b_addr][i*LANE_W +: LANE_W] <= b_wdata[i*LANE_W +: LANE_W];
            end
            if (a_we && a_lanes[i]) begin
                mem_q[a_addr][i*LANE_W +: LANE_W] <= a_wdata[i*LANE_W +: LANE_W];
            end
        end
    end

    // combinational read of the pre-edge contents
    assign a_word = mem_q[a_addr];
    assign b_word = mem_q[b_addr];
endmodule

// File: rtl/dpram_rdport.sv
module dpram_rdport #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr,
    input  logic              oe,
    input  logic [LANES-1:0]  lanes,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int LANE_W = DATA_W / LANES;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } out_t;

    out_t              out_d, out_q;
    logic [DATA_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            mask[i*LANE_W +: LANE_W] = {LANE_W{lanes[i]}};
        end
        out_d.vld  = en && oe && !wr;
        out_d.data = out_d.vld ? (word & mask) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.vld  <= 1'b0;
            out_q.data <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rdata  = out_q.data;
    assign rvalid = out_q.vld;
endmodule

// File: rtl/dpram_arb.sv
module dpram_arb #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 is_master,
    input  logic                                 ext_a_busy_n,
    input  logic                                 ext_b_busy_n,
    input  logic                                 a_en,
    input  logic                                 a_wr,
    input  logic                                 a_oe,
    input  logic [DATA_W/dpram_pkg::LANE_W-1:0]  a_be,
    input  logic [ADDR_W-1:0]                    a_addr,
    input  logic [DATA_W-1:0]                    a_wdata,
    output logic [DATA_W-1:0]                    a_rdata,
    output logic                                 a_rvalid,
    output logic                                 a_busy_n,
    input  logic                                 b_en,
    input  logic                                 b_wr,
    input  logic                                 b_oe,
    input  logic [DATA_W/dpram_pkg::LANE_W-1:0]  b_be,
    input  logic [ADDR_W-1:0]                    b_addr,
    input  logic [DATA_W-1:0]                    b_wdata,
    output logic [DATA_W-1:0]                    b_rdata,
    output logic                                 b_rvalid,
    output logic                                 b_busy_n
);
    import dpram_pkg::*;

    localparam int LANES = DATA_W / LANE_W;

    logic              a_lose, b_lose;
    logic              a_we, b_we;
    logic [DATA_W-1:0] a_word, b_word;

    // per-side views for the generated read paths
    logic [N_SIDES-1:0] en_v, wr_v, oe_v, vld_v;
    logic [LANES-1:0]   lanes_v [N_SIDES];
    logic [DATA_W-1:0]  word_v  [N_SIDES];
    logic [DATA_W-1:0]  rd_v    [N_SIDES];

    dpram_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .is_master    (is_master),
        .a_en         (a_en),
        .b_en         (b_en),
        .a_addr       (a_addr),
        .b_addr       (b_addr),
        .ext_a_busy_n (ext_a_busy_n),
        .ext_b_busy_n (ext_b_busy_n),
        .a_lose       (a_lose),
        .b_lose       (b_lose)
    );

    always_comb begin
        a_we = a_en && a_wr && !a_lose;
        b_we = b_en && b_wr && !b_lose;
    end

    dpram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_store (
        .clk     (clk),
        .a_we    (a_we),
        .a_lanes (a_be),
        .a_addr  (a_addr),
        .a_wdata (a_wdata),
        .b_we    (b_we),
        .b_lanes (b_be),
        .b_addr  (b_addr),
        .b_wdata (b_wdata),
        .a_word  (a_word),
        .b_word  (b_word)
    );

    always_comb begin
        en_v[SIDE_A]    = a_en;
        en_v[SIDE_B]    = b_en;
        wr_v[SIDE_A]    = a_wr;
        wr_v[SIDE_B]    = b_wr;
        oe_v[SIDE_A]    = a_oe;
        oe_v[SIDE_B]    = b_oe;
        lanes_v[SIDE_A] = a_be;
        lanes_v[SIDE_B] = b_be;
        word_v[SIDE_A]  = a_word;
        word_v[SIDE_B]  = b_word;
    end

    for (genvar s = 0; s < N_SIDES; s++) begin : g_rd
        dpram_rdport #(.DATA_W(DATA_W), .LANES(LANES)) u_rd (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en_v[s]),
            .wr     (wr_v[s]),
            .oe     (oe_v[s]),
            .lanes  (lanes_v[s]),
            .word   (word_v[s]),
            .rdata  (rd_v[s]),
            .rvalid (vld_v[s])
        );
    end

    assign a_rdata  = rd_v[SIDE_A];
    assign b_rdata  = rd_v[SIDE_B];
    assign a_rvalid = vld_v[SIDE_A];
    assign b_rvalid = vld_v[SIDE_B];
    assign a_busy_n = !a_lose;
    assign b_busy_n = !b_lose;
endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              is_master,
    input logic              ext_a_busy_n,
    input logic              ext_b_busy_n,
    input logic              a_en,
    input logic              a_wr,
    input logic              a_oe,
    input logic [ADDR_W-1:0] a_addr,
    input logic [DATA_W-1:0] a_rdata,
    input logic              a_rvalid,
    input logic              a_busy_n,
    input logic              b_en,
    input logic              b_wr,
    input logic              b_oe,
    input logic [ADDR_W-1:0] b_addr,
    input logic [DATA_W-1:0] b_rdata,
    input logic              b_rvalid,
    input logic              b_busy_n
);
    logic same_word;
    logic armed_q;

    assign same_word = a_en && b_en && (a_addr == b_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R7
    busy_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && (!a_busy_n || !b_busy_n)) |-> same_word);

    // R5
    single_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && same_word) |-> (a_busy_n != b_busy_n));

    // R6
    winner_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && is_master && $past(is_master) && same_word && $past(same_word)
         && $stable(a_addr) && $stable(b_addr)) |-> $stable(a_busy_n));

    // R3
    a_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_oe && !a_wr) |=> a_rvalid);

    // R3
    b_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(b_en && b_oe && !b_wr) |=> !b_rvalid);

    // R3
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_rvalid |-> a_rdata == '0) and (!b_rvalid |-> b_rdata == '0));

    // R10
    slave_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> (a_busy_n == ext_a_busy_n && b_busy_n == ext_b_busy_n));
endmodule

bind dpram_arb dpram_arb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_dpram_arb.sv
module sim_dpram_arb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int LN = 2;
    localparam int DEPTH = 1 << AW;

    logic clk, rst_n, is_master, ext_a_busy_n, ext_b_busy_n;
    logic a_en, a_wr, a_oe, b_en, b_wr, b_oe;
    logic [LN-1:0] a_be, b_be;
    logic [AW-1:0] a_addr, b_addr;
    logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
    logic a_rvalid, b_rvalid, a_busy_n, b_busy_n;

    dpram_arb #(.ADDR_W(AW), .DATA_W(DW)) u0 (.*);

    logic [DW-1:0] ref_mem [DEPTH];
    logic          h_ae, h_be, h_win;
    logic [AW-1:0] h_aa, h_ba;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] lane_mask(logic [LN-1:0] be);
        logic [DW-1:0] m;
        for (int i = 0; i < LN; i++) m[i*8 +: 8] = {8{be[i]}};
        return m;
    endfunction

    task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic drv_a(logic e, logic w, logic o, logic [LN-1:0] be, logic [AW-1:0] ad, logic [DW-1:0] d);
        a_en = e; a_wr = w; a_oe = o; a_be = be; a_addr = ad; a_wdata = d;
    endtask

    task automatic drv_b(logic e, logic w, logic o, logic [LN-1:0] be, logic [AW-1:0] ad, logic [DW-1:0] d);
        b_en = e; b_wr = w; b_oe = o; b_be = be; b_addr = ad; b_wdata = d;
    endtask

    // one cycle: busy checked before the edge, model updated at the edge,
    // registered read results checked at the following falling edge
    task automatic step(string t);
        logic m, ah, bh, wa, la, lb, va, vb;
        logic [DW-1:0] ea, eb;
        #1;
        m  = a_en && b_en && (a_addr == b_addr);
        ah = h_ae && (h_aa == a_addr);
        bh = h_be && (h_ba == b_addr);
        wa = (ah && bh) ? h_win : (bh ? 1'b0 : 1'b1);
        if (is_master) begin la = m && !wa; lb = m && wa; end
        else begin la = !ext_a_busy_n; lb = !ext_b_busy_n; end
        chk(t, "a_busy_n", a_busy_n, !la);
        chk(t, "b_busy_n", b_busy_n, !lb);
        @(posedge clk);
        va = a_en && a_oe && !a_wr;
        vb = b_en && b_oe && !b_wr;
        ea = va ? (ref_mem[a_addr] & lane_mask(a_be)) : '0;
        eb = vb ? (ref_mem[b_addr] & lane_mask(b_be)) : '0;
        for (int i = 0; i < LN; i++) begin
            if (b_en && b_wr && !lb && b_be[i]) ref_mem[b_addr][i*8 +: 8] = b_wdata[i*8 +: 8];
            if (a_en && a_wr && !la && a_be[i]) ref_mem[a_addr][i*8 +: 8] = a_wdata[i*8 +: 8];
        end
        h_ae = a_en; h_be = b_en; h_aa = a_addr; h_ba = b_addr;
        h_win = m ? wa : 1'b1;
        @(negedge clk);
        chk(t, "a_rvalid", a_rvalid, va);
        chk(t, "b_rvalid", b_rvalid, vb);
        chk(t, "a_rdata", a_rdata, ea);
        chk(t, "b_rdata", b_rdata, eb);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; is_master = 1'b1; ext_a_busy_n = 1'b1; ext_b_busy_n = 1'b1;
        drv_a(0, 0, 0, 2'b00, 0, 0);
        drv_b(0, 0, 0, 2'b00, 0, 0);
        h_ae = 0; h_be = 0; h_aa = 0; h_ba = 0; h_win = 1;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", "a_rvalid", a_rvalid, 0);
        chk("R11", "b_rvalid", b_rvalid, 0);
        chk("R11", "a_rdata", a_rdata, 0);
        chk("R11", "b_rdata", b_rdata, 0);
        chk("R11", "a_busy_n", a_busy_n, 1);
        chk("R11", "b_busy_n", b_busy_n, 1);
        rst_n = 1'b1;

        // R1 fill every word through the left port
        for (int i = 0; i < DEPTH; i++) begin
            drv_a(1, 1, 0, 2'b11, AW'(i), DW'($urandom));
            step("R1");
        end
        drv_a(1, 1, 0, 2'b11, 3, 16'h1234); step("R1");
        drv_a(1, 0, 1, 2'b11, 3, 0);        step("R1");
        // R2 partial write of lane 0, then read lane 1 only
        drv_a(1, 1, 0, 2'b01, 3, 16'habcd); step("R2");
        drv_a(1, 0, 1, 2'b10, 3, 0);        step("R2");
        drv_a(1, 0, 1, 2'b11, 3, 0);        step("R2");
        // R4 disabled write must not land; R3 oe low gives no valid
        drv_a(0, 1, 1, 2'b11, 3, 16'hffff); step("R4");
        drv_a(1, 0, 0, 2'b11, 3, 0);        step("R3");
        drv_a(1, 0, 1, 2'b11, 3, 0);        step("R4");
        drv_a(0, 0, 0, 2'b11, 0, 0);        step("R4");
        // R5 fresh tie on reads: right flagged; R9 both get the word
        drv_a(1, 0, 1, 2'b11, 3, 0); drv_b(1, 0, 1, 2'b11, 3, 0); step("R5");
        drv_a(0, 0, 0, 2'b11, 0, 0); drv_b(0, 0, 0, 2'b11, 0, 0); step("R9");
        // R6 left parked, right arrives and is blocked (R8)
        drv_a(1, 0, 1, 2'b11, 5, 0);        step("R6");
        drv_b(1, 1, 0, 2'b11, 5, 16'hdead); step("R6");
        drv_b(1, 1, 0, 2'b11, 5, 16'hbeef); step("R8");
        drv_a(0, 0, 0, 2'b11, 0, 0); drv_b(1, 0, 1, 2'b11, 5, 0); step("R7");
        // R6 right parked, left arrives and loses, collision persists
        drv_b(1, 0, 1, 2'b11, 6, 0); step("R6");
        drv_a(1, 1, 0, 2'b11, 6, 16'h0f0f); step("R6");
        drv_a(1, 1, 0, 2'b11, 6, 16'hf0f0); step("R6");
        drv_a(1, 0, 1, 2'b11, 7, 0);        step("R7");
        // R8 both write one word on a fresh tie: left lands
        drv_a(0, 0, 0, 2'b11, 0, 0); drv_b(0, 0, 0, 2'b11, 0, 0); step("R8");
        drv_a(1, 1, 0, 2'b11, 7, 16'h1111); drv_b(1, 1, 0, 2'b11, 7, 16'h2222); step("R8");
        drv_a(0, 0, 0, 2'b11, 0, 0); drv_b(1, 0, 1, 2'b11, 7, 0); step("R8");
        // R9 loser reads while winner writes: old word returned
        drv_b(0, 0, 0, 2'b11, 0, 0); step("R9");
        drv_a(1, 1, 0, 2'b11, 7, 16'h7777); drv_b(1, 0, 1, 2'b11, 7, 0); step("R9");
        drv_a(0, 0, 0, 2'b11, 0, 0); step("R9");
        drv_b(0, 0, 0, 2'b11, 0, 0); step("R9");

        // R10 slave mode: external busy blocks a write with no address match
        is_master = 1'b0; ext_a_busy_n = 1'b0; ext_b_busy_n = 1'b1;
        drv_a(1, 1, 0, 2'b11, 8, 16'h8888); drv_b(1, 1, 0, 2'b11, 9, 16'h9999); step("R10");
        ext_a_busy_n = 1'b1;
        drv_a(1, 0, 1, 2'b11, 8, 0); drv_b(1, 0, 1, 2'b11, 9, 0); step("R10");

        // R7 random master traffic on a small address space
        is_master = 1'b1; ext_a_busy_n = 1'b1; ext_b_busy_n = 1'b1;
        for (int n = 0; n < 2000; n++) begin
            drv_a(($urandom % 4) != 0, $urandom % 2, $urandom % 2, LN'($urandom),
                  AW'($urandom), DW'($urandom));
            drv_b(($urandom % 4) != 0, $urandom % 2, $urandom % 2, LN'($urandom),
                  AW'($urandom), DW'($urandom));
            step("R7");
        end

        // R10 random slave traffic with random external busy levels
        is_master = 1'b0;
        for (int n = 0; n < 1000; n++) begin
            ext_a_busy_n = ($urandom % 3) != 0;
            ext_b_busy_n = ($urandom % 3) != 0;
            drv_a(($urandom % 4) != 0, $urandom % 2, $urandom % 2, LN'($urandom),
                  AW'($urandom), DW'($urandom));
            drv_b(($urandom % 4) != 0, $urandom % 2, $urandom % 2, LN'($urandom),
                  AW'($urandom), DW'($urandom));
            step("R10");
        end

        finish_run();
    end
endmodule